// File: doc/BRIEF.md
# Prefetch and Demand Request Merger

This block sits where upstream requests enter a cache slice, in front of the table of outstanding miss entries. Each cycle it may receive one request. If the request is a demand Acquire and its line address equals that of a live miss entry that a prefetch started, the Acquire is folded into that entry rather than placed in the request queue. The entry is marked as holding a merged demand, and the block remembers the requester's source identifier and whether it asked for write permission. Every other request goes unchanged to the fallback enqueue path.

When the downstream data for a prefetch-started entry returns, the block issues a single pipeline task for that entry. It always acknowledges the prefetch. If a demand was merged into the entry, the same task also carries a data grant to the demand's source, a training notice for the prefetcher, and the line state the Acquire asked for. One downstream fetch therefore answers two requesters, and a late demand never blocks behind its own prefetch.

The miss entries themselves (address, valid, prefetch origin, data-return strobe) are inputs from the miss-handling logic. All decisions are registered, so every output appears one clock after the inputs that caused it.

Top module: `pdm_merger`

## Requirements
- R1: Request kinds are encoded 0 = Get, 1 = AcquireShared, 2 = AcquireUnique, 3 = Hint. An Acquire (kind 1 or 2) whose address equals that of an entry with valid=1, prefetch=1, not already merged and not returning data this cycle raises mrg_valid one cycle later, with mrg_idx set to that entry and mrg_src set to the request's source.
- R2: Each valid request produces exactly one outcome one cycle later: either a merge or enq_valid with kind, address and source unchanged. Get, Hint, and any Acquire that finds no candidate are enqueued.
- R3: When several entries qualify, the lowest-numbered entry receives the merge.
- R4: An Acquire matching only an entry that already holds a merged demand is enqueued and does not merge.
- R5: An Acquire whose only matching entry has its data-return strobe high in the same cycle is enqueued and does not merge.
- R6: A data return on a valid prefetch entry without a merged demand raises task_valid and pf_ack_valid one cycle later, with task_idx set to that entry, task_state = 1 (shared), task_client = 0, and no grant or training notice.
- R7: A data return on an entry that holds a merged demand also raises grant_valid and train_valid, with grant_src set to the Acquire's source and grant_unique = 1 for AcquireUnique. It sets task_client = 1 and task_state = 3 (tip) for AcquireUnique or 1 for AcquireShared.
- R8: A data-return strobe on an entry that is invalid or was not started by a prefetch produces no task, acknowledgement or grant. If several strobes qualify in one cycle, the lowest-numbered entry is served.
- R9: The merged mark of an entry is cleared by reset, by that entry's served data return and by the entry going invalid, after which a new Acquire can merge into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request present |
| req_kind | input | 2 | Request kind (R1 encoding) |
| req_addr | input | ADDR_W | Line address of the request |
| req_src | input | SRC_W | Requester source identifier |
| ent_valid | input | N_ENT | Miss entry live |
| ent_pf | input | N_ENT | Miss entry started by a prefetch |
| ent_addr | input | N_ENT*ADDR_W | Entry line addresses, entry i at bits i*ADDR_W |
| ent_refill | input | N_ENT | Data return strobe per entry |
| mrg_valid | output | 1 | Request merged into an entry |
| mrg_idx | output | IDX_W | Entry receiving the merge |
| mrg_src | output | SRC_W | Source of the merged Acquire |
| enq_valid | output | 1 | Request forwarded to the queue |
| enq_kind | output | 2 | Forwarded kind |
| enq_addr | output | ADDR_W | Forwarded address |
| enq_src | output | SRC_W | Forwarded source |
| task_valid | output | 1 | Pipeline task for a returned entry |
| task_idx | output | IDX_W | Entry of the task |
| task_state | output | 2 | Line state the task writes |
| task_client | output | 1 | Upstream client holds the line |
| pf_ack_valid | output | 1 | Prefetch acknowledgement |
| grant_valid | output | 1 | Data grant to the merged demand |
| grant_src | output | SRC_W | Destination of the grant |
| grant_unique | output | 1 | Grant gives write permission |
| train_valid | output | 1 | Training notice to the prefetcher |

## Verification
The merge test is swept over every combination of request kind, entry valid mask, prefetch-origin mask and address-match mask on a four-entry setup. This separates the kind filter, the valid and origin qualifiers, the address compare and the lowest-index priority. Directed sequences then cover the response side. A merged unique demand and a merged shared demand are told apart by grant permission and written state, and a plain prefetch return is told apart by the absence of a grant. A second Acquire against a merged entry, a merge attempt in the cycle the data returns, strobes on demand-origin entries, and re-merging after the mark is cleared each show a distinct refusal or reuse rule.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
   typedef enum logic [1:0] {
      K_GET       = 2'd0,
      K_ACQ_SHR   = 2'd1,
      K_ACQ_UNQ   = 2'd2,
      K_HINT      = 2'd3
   } req_kind_e;

   localparam logic [1:0] ST_SHARED = 2'd1;
   localparam logic [1:0] ST_TIP    = 2'd3;

   function automatic logic is_acquire(input logic [1:0] k);
      return (k == K_ACQ_SHR) || (k == K_ACQ_UNQ);
   endfunction
endpackage

// File: rtl/pdm_match.sv
module pdm_match #(
   parameter int N_ENT  = 16,
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [N_ENT*ADDR_W-1:0] ent_addr,
   input  logic [N_ENT-1:0]        ent_valid,
   input  logic [N_ENT-1:0]        ent_pf,
   input  logic [N_ENT-1:0]        ent_merged,
   input  logic [N_ENT-1:0]        ent_refill,
   output logic [N_ENT-1:0]        cand
);
   for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
      logic hit;
      assign hit     = (ent_addr[i*ADDR_W +: ADDR_W] == req_addr);
      assign cand[i] = hit & ent_valid[i] & ent_pf[i] & ~ent_merged[i] & ~ent_refill[i];
   end
endmodule

// File: rtl/pdm_prio.sv
module pdm_prio #(
   parameter int N     = 16,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/pdm_slot_state.sv
module pdm_slot_state #(
   parameter int N_ENT = 16,
   parameter int SRC_W = 6,
   parameter int IDX_W = $clog2(N_ENT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_en,
   input  logic [IDX_W-1:0]       set_idx,
   input  logic [SRC_W-1:0]       set_src,
   input  logic                   set_unique,
   input  logic [N_ENT-1:0]       clr_vec,
   output logic [N_ENT-1:0]       merged,
   output logic [N_ENT*SRC_W-1:0] src_flat,
   output logic [N_ENT-1:0]       unique_f
);
   for (genvar i = 0; i < N_ENT; i++) begin : g_slot
      logic             flag_q;
      logic [SRC_W-1:0] src_q;
      logic             unq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
            src_q  <= '0;
            unq_q  <= 1'b0;
         end else if (clr_vec[i]) begin
            flag_q <= 1'b0;
         end else if (set_en && set_idx == IDX_W'(i)) begin
            flag_q <= 1'b1;
            src_q  <= set_src;
            unq_q  <= set_unique;
         end
      end
      assign merged[i]                   = flag_q;
      assign src_flat[i*SRC_W +: SRC_W]  = src_q;
      assign unique_f[i]                 = unq_q;
   end
endmodule

// File: rtl/pdm_merger.sv
module pdm_merger #(
   parameter int N_ENT  = 16,
   parameter int ADDR_W = 32,
   parameter int SRC_W  = 6,
   parameter int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [1:0]              req_kind,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [SRC_W-1:0]        req_src,
   input  logic [N_ENT-1:0]        ent_valid,
   input  logic [N_ENT-1:0]        ent_pf,
   input  logic [N_ENT*ADDR_W-1:0] ent_addr,
   input  logic [N_ENT-1:0]        ent_refill,
   output logic                    mrg_valid,
   output logic [IDX_W-1:0]        mrg_idx,
   output logic [SRC_W-1:0]        mrg_src,
   output logic                    enq_valid,
   output logic [1:0]              enq_kind,
   output logic [ADDR_W-1:0]       enq_addr,
   output logic [SRC_W-1:0]        enq_src,
   output logic                    task_valid,
   output logic [IDX_W-1:0]        task_idx,
   output logic [1:0]              task_state,
   output logic                    task_client,
   output logic                    pf_ack_valid,
   output logic                    grant_valid,
   output logic [SRC_W-1:0]        grant_src,
   output logic                    grant_unique,
   output logic                    train_valid
);
   import pdm_pkg::*;

   if (N_ENT < 2) begin : g_bad_n
      $error("pdm_merger: N_ENT must be at least 2");
   end
   if (ADDR_W < 1 || SRC_W < 1) begin : g_bad_w
      $error("pdm_merger: ADDR_W and SRC_W must be positive");
   end
   if (IDX_W < $clog2(N_ENT)) begin : g_bad_idx
      $error("pdm_merger: IDX_W too narrow for N_ENT");
   end

   logic [N_ENT-1:0]       merged;
   logic [N_ENT*SRC_W-1:0] src_flat;
   logic [N_ENT-1:0]       unique_f;
   logic [N_ENT-1:0]       cand;
   logic                   c_found;
   logic [IDX_W-1:0]       c_idx;
   logic [N_ENT-1:0]       rf_hit;
   logic                   r_found;
   logic [IDX_W-1:0]       r_idx;
   logic [N_ENT-1:0]       r_onehot;
   logic                   do_merge;
   logic                   is_acq;

   pdm_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_match (
      .req_addr   (req_addr),
      .ent_addr   (ent_addr),
      .ent_valid  (ent_valid),
      .ent_pf     (ent_pf),
      .ent_merged (merged),
      .ent_refill (ent_refill),
      .cand       (cand)
   );

   pdm_prio #(.N(N_ENT), .IDX_W(IDX_W)) u_cand_pick (
      .vec   (cand),
      .found (c_found),
      .idx   (c_idx)
   );

   assign rf_hit = ent_refill & ent_valid & ent_pf;

   pdm_prio #(.N(N_ENT), .IDX_W(IDX_W)) u_refill_pick (
      .vec   (rf_hit),
      .found (r_found),
      .idx   (r_idx)
   );

   assign is_acq   = is_acquire(req_kind);
   assign do_merge = req_valid & is_acq & c_found;
   assign r_onehot = r_found ? (N_ENT'(1) << r_idx) : '0;

   pdm_slot_state #(.N_ENT(N_ENT), .SRC_W(SRC_W), .IDX_W(IDX_W)) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en     (do_merge),
      .set_idx    (c_idx),
      .set_src    (req_src),
      .set_unique (req_kind == K_ACQ_UNQ),
      .clr_vec    (~ent_valid | r_onehot),
      .merged     (merged),
      .src_flat   (src_flat),
      .unique_f   (unique_f)
   );

   logic             sel_merged;
   logic             sel_unique;
   logic [SRC_W-1:0] sel_src;
   assign sel_merged = merged[r_idx];
   assign sel_unique = unique_f[r_idx];
   assign sel_src    = src_flat[r_idx*SRC_W +: SRC_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mrg_valid <= 1'b0;
         mrg_idx   <= '0;
         mrg_src   <= '0;
         enq_valid <= 1'b0;
         enq_kind  <= '0;
         enq_addr  <= '0;
         enq_src   <= '0;
      end else begin
         mrg_valid <= do_merge;
         mrg_idx   <= do_merge ? c_idx : '0;
         mrg_src   <= do_merge ? req_src : '0;
         enq_valid <= req_valid & ~do_merge;
         enq_kind  <= req_kind;
         enq_addr  <= req_addr;
         enq_src   <= req_src;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         task_valid   <= 1'b0;
         task_idx     <= '0;
         task_state   <= '0;
         task_client  <= 1'b0;
         pf_ack_valid <= 1'b0;
         grant_valid  <= 1'b0;
         grant_src    <= '0;
         grant_unique <= 1'b0;
         train_valid  <= 1'b0;
      end else begin
         task_valid   <= r_found;
         task_idx     <= r_idx;
         task_state   <= (sel_merged && sel_unique) ? ST_TIP : ST_SHARED;
         task_client  <= r_found & sel_merged;
         pf_ack_valid <= r_found;
         grant_valid  <= r_found & sel_merged;
         grant_src    <= sel_src;
         grant_unique <= r_found & sel_merged & sel_unique;
         train_valid  <= r_found & sel_merged;
      end
   end
endmodule

// File: rtl/pdm_merger_chk.sv
module pdm_merger_chk #(
   parameter int N_ENT  = 16,
   parameter int IDX_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             mrg_valid,
   input logic [IDX_W-1:0] mrg_idx,
   input logic             enq_valid,
   input logic             task_valid,
   input logic             pf_ack_valid,
   input logic             grant_valid,
   input logic             grant_unique,
   input logic             train_valid,
   input logic             task_client
);
   // R2: a request yields exactly one outcome one cycle later
   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (mrg_valid ^ enq_valid));

   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(mrg_valid || enq_valid));

   // R1: merge target names a real entry
   a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      mrg_valid |-> (int'(mrg_idx) < N_ENT));

   // R6: every task on a prefetch entry acknowledges the prefetch
   a_r6_ack_with_task: assert property (@(posedge clk) disable iff (!rst_n)
      task_valid == pf_ack_valid);

   // R7: a grant rides on a task and is paired with training
   a_r7_grant_in_task: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (task_valid && train_valid && task_client));

   a_r7_unique_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      grant_unique |-> grant_valid);
endmodule

bind pdm_merger pdm_merger_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .mrg_valid    (mrg_valid),
   .mrg_idx      (mrg_idx),
   .enq_valid    (enq_valid),
   .task_valid   (task_valid),
   .pf_ack_valid (pf_ack_valid),
   .grant_valid  (grant_valid),
   .grant_unique (grant_unique),
   .train_valid  (train_valid),
   .task_client  (task_client)
);

// File: tb/pdm_merger_bench.sv
module pdm_merger_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int AW = 8;
   localparam int SW = 3;
   localparam int IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = '0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_src = '0;
   logic [N-1:0]  ent_valid = '0;
   logic [N-1:0]  ent_pf = '0;
   logic [N*AW-1:0] ent_addr = '0;
   logic [N-1:0]  ent_refill = '0;
   logic          mrg_valid, enq_valid, task_valid, task_client, pf_ack_valid;
   logic          grant_valid, grant_unique, train_valid;
   logic [IW-1:0] mrg_idx, task_idx;
   logic [SW-1:0] mrg_src, enq_src, grant_src;
   logic [1:0]    enq_kind, task_state;
   logic [AW-1:0] enq_addr;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   pdm_merger #(.N_ENT(N), .ADDR_W(AW), .SRC_W(SW), .IDX_W(IW)) u_pdm_merger (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_src(req_src), .ent_valid(ent_valid),
      .ent_pf(ent_pf), .ent_addr(ent_addr), .ent_refill(ent_refill),
      .mrg_valid(mrg_valid), .mrg_idx(mrg_idx), .mrg_src(mrg_src),
      .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_addr(enq_addr),
      .enq_src(enq_src), .task_valid(task_valid), .task_idx(task_idx),
      .task_state(task_state), .task_client(task_client),
      .pf_ack_valid(pf_ack_valid), .grant_valid(grant_valid),
      .grant_src(grant_src), .grant_unique(grant_unique),
      .train_valid(train_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      req_valid  = 1'b0;
      ent_refill = '0;
   endtask

   task automatic send(input logic [1:0] k, input logic [AW-1:0] a, input logic [SW-1:0] s);
      @(negedge clk);
      idle();
      req_valid = 1'b1; req_kind = k; req_addr = a; req_src = s;
      @(negedge clk);
   endtask

   task automatic refill(input logic [N-1:0] r);
      @(negedge clk);
      idle();
      ent_refill = r;
      @(negedge clk);
   endtask

   task automatic set_addr(input int i, input logic [AW-1:0] a);
      ent_addr[i*AW +: AW] = a;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R9 reset mrg", {31'b0, mrg_valid}, 0);
      check("R9 reset enq", {31'b0, enq_valid}, 0);
      check("R9 reset task", {31'b0, task_valid}, 0);
      check("R9 reset grant", {31'b0, grant_valid}, 0);

      // sweep: kind x valid x prefetch x address match
      for (int k = 0; k < 4; k++)
         for (int v = 0; v < 16; v++)
            for (int p = 0; p < 16; p++)
               for (int m = 0; m < 16; m++) begin
                  logic [N-1:0] cnd;
                  bit acq, exp_m;
                  int exp_i;
                  logic [SW-1:0] s;
                  s = SW'(k + v + p + m);
                  @(negedge clk);
                  idle();
                  ent_valid = N'(v); ent_pf = N'(p);
                  for (int i = 0; i < N; i++)
                     set_addr(i, m[i] ? 8'h10 : AW'(8'h20 + i));
                  req_valid = 1'b1; req_kind = 2'(k); req_addr = 8'h10; req_src = s;
                  @(negedge clk);
                  cnd = N'(v & p & m);
                  acq = (k == 1) || (k == 2);
                  exp_m = acq && (cnd != 0);
                  exp_i = 0;
                  for (int i = N - 1; i >= 0; i--) if (cnd[i]) exp_i = i;
                  check("R1 merge flag", {31'b0, mrg_valid}, {31'b0, exp_m});
                  check("R2 enqueue flag", {31'b0, enq_valid}, {31'b0, !exp_m});
                  if (exp_m) begin
                     check("R3 merge index", {30'b0, mrg_idx}, exp_i);
                     check("R1 merge src", {29'b0, mrg_src}, {29'b0, s});
                  end else begin
                     check("R2 enq kind", {30'b0, enq_kind}, k);
                     check("R2 enq addr", {24'b0, enq_addr}, 32'h10);
                     check("R2 enq src", {29'b0, enq_src}, {29'b0, s});
                  end
                  // drop entries for one cycle to clear merged marks (R9)
                  idle();
                  ent_valid = '0;
               end

      // directed: e0 pf 0x33, e1 pf 0x55, e2 demand 0x77, e3 invalid
      @(negedge clk);
      idle();
      ent_valid = 4'b0111; ent_pf = 4'b0011;
      set_addr(0, 8'h33); set_addr(1, 8'h55); set_addr(2, 8'h77); set_addr(3, 8'h99);
      send(2'd2, 8'h55, 3'd5);
      check("R1 merge unique", {31'b0, mrg_valid}, 1);
      check("R1 merge idx", {30'b0, mrg_idx}, 1);
      send(2'd1, 8'h55, 3'd6);
      check("R4 second acquire no merge", {31'b0, mrg_valid}, 0);
      check("R4 second acquire queued", {31'b0, enq_valid}, 1);
      refill(4'b0010);
      check("R7 task", {31'b0, task_valid}, 1);
      check("R7 task idx", {30'b0, task_idx}, 1);
      check("R7 pf ack", {31'b0, pf_ack_valid}, 1);
      check("R7 grant", {31'b0, grant_valid}, 1);
      check("R7 grant src", {29'b0, grant_src}, 5);
      check("R7 grant unique", {31'b0, grant_unique}, 1);
      check("R7 state tip", {30'b0, task_state}, 3);
      check("R7 client", {31'b0, task_client}, 1);
      check("R7 train", {31'b0, train_valid}, 1);
      refill(4'b0001);
      check("R6 task", {31'b0, task_valid}, 1);
      check("R6 task idx", {30'b0, task_idx}, 0);
      check("R6 pf ack", {31'b0, pf_ack_valid}, 1);
      check("R6 no grant", {31'b0, grant_valid}, 0);
      check("R6 no train", {31'b0, train_valid}, 0);
      check("R6 state shared", {30'b0, task_state}, 1);
      check("R6 client", {31'b0, task_client}, 0);
      // mark cleared by served return: merges again (R9)
      send(2'd1, 8'h55, 3'd2);
      check("R9 remerge after return", {31'b0, mrg_valid}, 1);
      refill(4'b0010);
      check("R7 shared grant", {31'b0, grant_valid}, 1);
      check("R7 shared src", {29'b0, grant_src}, 2);
      check("R7 shared not unique", {31'b0, grant_unique}, 0);
      check("R7 shared state", {30'b0, task_state}, 1);
      refill(4'b0100);
      check("R8 demand entry no task", {31'b0, task_valid}, 0);
      check("R8 demand entry no grant", {31'b0, grant_valid}, 0);
      refill(4'b1000);
      check("R8 invalid entry no task", {31'b0, task_valid}, 0);
      refill(4'b0011);
      check("R8 lowest refill served", {30'b0, task_idx}, 0);
      // same-cycle return refuses merge (R5)
      @(negedge clk);
      idle();
      req_valid = 1'b1; req_kind = 2'd2; req_addr = 8'h33; req_src = 3'd4;
      ent_refill = 4'b0001;
      @(negedge clk);
      check("R5 refused merge", {31'b0, mrg_valid}, 0);
      check("R5 queued", {31'b0, enq_valid}, 1);
      check("R5 task still issued", {31'b0, task_valid}, 1);
      check("R5 no grant", {31'b0, grant_valid}, 0);
      idle();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            fails++;
            vectors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule